// File: doc/BRIEF.md
# IDE Bus-Master DMA Register Block

This block holds the software-visible registers of a two-channel bus-master DMA controller for an IDE disk interface. Each channel has a command register, a status register, a drive-unit select bit, and a descriptor-table base address. A byte-addressed register bus reaches all of them and supports byte, halfword and word accesses. Command writes have side effects. A start write on an idle channel raises a one-cycle start strobe to an external transfer engine. A stop write on an active channel raises a one-cycle abort strobe. The engine reports back with done and error pulses.

The block also keeps a current descriptor pointer per channel for the engine to use. Any write to the table base reloads this pointer. The engine then advances it by one descriptor at a time through an increment input. The register bus carries no stream: it takes one access per cycle, has no back-pressure and no handshake, and returns read data combinationally in the cycle of the request. The engine pins are plain control strobes.

The address map uses the low byte offset within each channel; channel c starts at byte address c*8. The offsets are:

- 0: command
- 1: unit
- 2: status
- 4..7: table base

Offset 3 reads as zero.

Top module: `bmdma_regs`

## Requirements
- R1: The command register keeps only bit 0 (run) and bit 3 (direction). Every other written bit reads back as 0, so a write of 0xFF reads back as 0x09. Bit 3 drives `eng_dir`.
- R2: A command write with bit 0 clear on an active channel does three things: it pulses `eng_abort` for one cycle in the cycle after the write, it clears status bit 0, and it stores the masked value. The same write on an idle channel raises no abort.
- R3: A command write with bit 0 set on an idle channel sets status bit 0 and pulses `eng_start` for one cycle in the cycle after the write. On a channel that is already active it raises no start, but the masked value is still stored.
- R4: A write to the table base merges the written lanes at a shift of (address[1:0] × 8). Size codes are 0 = byte, 1 = halfword, 2 = word. Byte and halfword write data are taken right-justified from `bus_wdata`. A word write replaces the whole value.
- R5: Bits [1:0] of the table base read as 0 after every write, whatever the width.
- R6: Every table-base write copies the resulting full value into that channel's current pointer.
- R7: Byte and halfword reads of the table base return the value shifted right by (address[1:0] × 8) and masked to 8 or 16 bits. Word reads return the whole value. Command, unit and status read zero-extended.
- R8: The two channels are independent: an access to one channel changes no register of the other. The unit register stores only written bit 0 and drives `drv_unit`.
- R9: Status bit 0 is active, bit 1 is error and bit 2 is interrupt. Writing 1 to bit 1 or bit 2 clears that bit. Bit 0 cannot be changed by a status write. `irq` follows bit 2.
- R10: A pulse on `eng_done` does three things: it clears the active bit, it sets the interrupt bit, and it also sets the error bit when `eng_err` is high in the same cycle. When a set and a status-write clear of the same bit fall in the same cycle, the set wins.
- R11: `eng_incr` adds 8 to the current pointer and leaves the table base unchanged. A table-base write in the same cycle wins over the increment.
- R12: After reset every register reads 0, `cur_ptr` is 0, and no start or abort strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | input | DW | Write data, right-justified |
| bus_rdata | output | DW | Read data for the current request |
| eng_start | output | NCH | One-cycle start strobe per channel |
| eng_abort | output | NCH | One-cycle abort strobe per channel |
| eng_dir | output | NCH | Stored direction bit per channel |
| drv_unit | output | NCH | Selected drive unit per channel |
| irq | output | NCH | Interrupt status bit per channel |
| eng_done | input | NCH | Transfer completion pulse |
| eng_err | input | NCH | Error qualifier for eng_done |
| eng_incr | input | NCH | Advance current pointer by one descriptor |
| cur_ptr | output | NCH*DW | Current descriptor pointer, channel c at bits [c*DW +: DW] |

## Verification
The bench checks four kinds of corner case.

- **Sub-word writes to the table base at non-zero offsets.** A design that shifted or masked the lanes wrongly would corrupt neighbouring bytes. A design that skipped the alignment clear would leave bits [1:0] set.
- **A start repeated on an already-active channel, and stops on idle and on active channels.** A wrong design would pulse a second start, or abort when nothing is running.
- **Write-one-to-clear status writes that try to touch the active bit, and completion with and without error.** Mistakes here show up as a stuck or spuriously cleared active bit, or as a missing error flag.
- **A table-base write in the same cycle as an increment, and cross-channel accesses.** A wrong priority leaves a stale pointer advanced by 8. A decode error leaks writes into the other channel.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [2:0] OFF_CMD  = 3'd0;
  localparam logic [2:0] OFF_UNIT = 3'd1;
  localparam logic [2:0] OFF_STAT = 3'd2;

  localparam int unsigned CMD_RUN  = 0;
  localparam int unsigned CMD_DIR  = 3;
  localparam logic [7:0]  CMD_KEEP = 8'h09;

  localparam int unsigned ST_ACT = 0;
  localparam int unsigned ST_ERR = 1;
  localparam int unsigned ST_IRQ = 2;
endpackage

// File: rtl/bmdma_lane.sv
module bmdma_lane
  import bmdma_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] cur_val,
  input  logic [DW-1:0] wval,
  input  logic [1:0]    off,
  input  logic [1:0]    size,
  output logic [DW-1:0] merged,
  output logic [DW-1:0] rd_val
);
  localparam logic [DW-1:0] ALIGN  = {{(DW-2){1'b1}}, 2'b00};
  localparam logic [DW-1:0] MASK_B = {{(DW-8){1'b0}}, 8'hFF};
  localparam logic [DW-1:0] MASK_H = {{(DW-16){1'b0}}, 16'hFFFF};

  logic [4:0]    shamt;
  logic [DW-1:0] lane_mask;

  assign shamt = {off, 3'b000};

  always_comb begin
    if (size == SZ_BYTE) lane_mask = MASK_B;
    else                 lane_mask = MASK_H;
  end

  always_comb begin
    if (size == SZ_WORD)
      merged = wval & ALIGN;
    else
      merged = ((cur_val & ~(lane_mask << shamt)) | ((wval & lane_mask) << shamt)) & ALIGN;
  end

  always_comb begin
    if (size == SZ_WORD) rd_val = cur_val;
    else                 rd_val = (cur_val >> shamt) & lane_mask;
  end
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned PTR_STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic          unit_we,
  input  logic          stat_we,
  input  logic          ptr_we,
  input  logic [7:0]    wbyte,
  input  logic [DW-1:0] ptr_wval,
  input  logic          done,
  input  logic          err,
  input  logic          incr,
  output logic [7:0]    cmd_q,
  output logic [7:0]    stat_q,
  output logic          unit_q,
  output logic [DW-1:0] tbase_q,
  output logic [DW-1:0] cur_q,
  output logic          start_o,
  output logic          abort_o
);
  localparam logic [DW-1:0] STEP = DW'(PTR_STEP);

  logic       launch, halt;
  logic [7:0] stat_n;

  assign launch = cmd_we &  wbyte[CMD_RUN] & ~stat_q[ST_ACT];
  assign halt   = cmd_we & ~wbyte[CMD_RUN] &  stat_q[ST_ACT];

  always_comb begin
    stat_n = stat_q;
    stat_n[7:3] = '0;
    if (stat_we) begin
      if (wbyte[ST_ERR]) stat_n[ST_ERR] = 1'b0;
      if (wbyte[ST_IRQ]) stat_n[ST_IRQ] = 1'b0;
    end
    if (launch)            stat_n[ST_ACT] = 1'b1;
    else if (halt || done) stat_n[ST_ACT] = 1'b0;
    if (done) begin
      stat_n[ST_IRQ] = 1'b1;
      if (err) stat_n[ST_ERR] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      stat_q  <= '0;
      unit_q  <= 1'b0;
      tbase_q <= '0;
      cur_q   <= '0;
      start_o <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      start_o <= launch;
      abort_o <= halt;
      stat_q  <= stat_n;
      if (cmd_we)  cmd_q  <= wbyte & CMD_KEEP;
      if (unit_we) unit_q <= wbyte[0];
      if (ptr_we) begin
        tbase_q <= ptr_wval;
        cur_q   <= ptr_wval;
      end else if (incr) begin
        cur_q <= cur_q + STEP;
      end
    end
  end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int unsigned NCH      = 2,
  parameter int unsigned AW       = 4,
  parameter int unsigned DW       = 32,
  parameter int unsigned PTR_STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NCH-1:0]    eng_start,
  output logic [NCH-1:0]    eng_abort,
  output logic [NCH-1:0]    eng_dir,
  output logic [NCH-1:0]    drv_unit,
  output logic [NCH-1:0]    irq,
  input  logic [NCH-1:0]    eng_done,
  input  logic [NCH-1:0]    eng_err,
  input  logic [NCH-1:0]    eng_incr,
  output logic [NCH*DW-1:0] cur_ptr
);
  localparam int unsigned CH_W = AW - 3;

  logic [CH_W-1:0] ch_sel;
  logic [2:0]      off3;

  logic [NCH-1:0][7:0]    cmd_q, stat_q;
  logic [NCH-1:0][DW-1:0] tbase_q, cur_q, rd_ch, merged, lane_rd;
  logic [NCH-1:0]         hit, ptr_we, unit_q;

  assign ch_sel = bus_addr[AW-1:3];
  assign off3   = bus_addr[2:0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic wr;
    assign hit[g]    = bus_req && (ch_sel == CH_W'(g));
    assign wr        = hit[g] && bus_we;
    assign ptr_we[g] = wr && off3[2];

    bmdma_lane #(.DW(DW)) u_lane (
      .cur_val (tbase_q[g]),
      .wval    (bus_wdata),
      .off     (off3[1:0]),
      .size    (bus_size),
      .merged  (merged[g]),
      .rd_val  (lane_rd[g])
    );

    bmdma_chan #(.DW(DW), .PTR_STEP(PTR_STEP)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_we   (wr && off3 == OFF_CMD),
      .unit_we  (wr && off3 == OFF_UNIT),
      .stat_we  (wr && off3 == OFF_STAT),
      .ptr_we   (ptr_we[g]),
      .wbyte    (bus_wdata[7:0]),
      .ptr_wval (merged[g]),
      .done     (eng_done[g]),
      .err      (eng_err[g]),
      .incr     (eng_incr[g]),
      .cmd_q    (cmd_q[g]),
      .stat_q   (stat_q[g]),
      .unit_q   (unit_q[g]),
      .tbase_q  (tbase_q[g]),
      .cur_q    (cur_q[g]),
      .start_o  (eng_start[g]),
      .abort_o  (eng_abort[g])
    );

    always_comb begin
      rd_ch[g] = '0;
      if (off3[2])                rd_ch[g] = lane_rd[g];
      else if (off3 == OFF_CMD)   rd_ch[g] = DW'(cmd_q[g]);
      else if (off3 == OFF_UNIT)  rd_ch[g] = DW'(unit_q[g]);
      else if (off3 == OFF_STAT)  rd_ch[g] = DW'(stat_q[g]);
    end

    assign eng_dir[g]             = cmd_q[g][CMD_DIR];
    assign drv_unit[g]            = unit_q[g];
    assign irq[g]                 = stat_q[g][ST_IRQ];
    assign cur_ptr[g*DW +: DW]    = cur_q[g];
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NCH; c++)
      if (hit[c] && !bus_we) bus_rdata = bus_rdata | rd_ch[c];
  end
endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk #(
  parameter int unsigned NCH = 2,
  parameter int unsigned DW  = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         eng_start,
  input logic [NCH-1:0]         eng_abort,
  input logic [NCH-1:0]         eng_done,
  input logic [NCH-1:0]         irq,
  input logic [NCH-1:0][7:0]    cmd_v,
  input logic [NCH-1:0][7:0]    stat_v,
  input logic [NCH-1:0][DW-1:0] tbase_v,
  input logic [NCH-1:0][DW-1:0] cur_v,
  input logic [NCH-1:0]         ptr_we_v
);
  for (genvar g = 0; g < NCH; g++) begin : g_a
    p_cmd_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_v[g] & 8'hF6) == 8'h00);
    p_no_both_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(eng_start[g] && eng_abort[g]));
    p_abort_leaves_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_abort[g] |-> !stat_v[g][0]);
    p_start_marks_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start[g] |-> stat_v[g][0]);
    p_base_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tbase_v[g][1:0] == 2'b00);
    p_ptr_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_we_v[g] |=> cur_v[g] == tbase_v[g]);
    p_done_raises_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done[g] |=> irq[g]);
  end
endmodule

bind bmdma_regs bmdma_regs_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .eng_start (eng_start),
  .eng_abort (eng_abort),
  .eng_done  (eng_done),
  .irq       (irq),
  .cmd_v     (cmd_q),
  .stat_v    (stat_q),
  .tbase_v   (tbase_q),
  .cur_v     (cur_q),
  .ptr_we_v  (ptr_we)
);

// File: tb/bmdma_regs_test.sv
`timescale 1ns/1ps
module bmdma_regs_test;
  localparam int NCH = 2;
  localparam int AW  = 4;
  localparam int DW  = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_req = 1'b0, bus_we = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [1:0]        bus_size = '0;
  logic [DW-1:0]     bus_wdata = '0;
  logic [DW-1:0]     bus_rdata;
  logic [NCH-1:0]    eng_start, eng_abort, eng_dir, drv_unit, irq;
  logic [NCH-1:0]    eng_done = '0, eng_err = '0, eng_incr = '0;
  logic [NCH*DW-1:0] cur_ptr;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  bmdma_regs #(.NCH(NCH), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .eng_start(eng_start), .eng_abort(eng_abort),
    .eng_dir(eng_dir), .drv_unit(drv_unit), .irq(irq), .eng_done(eng_done),
    .eng_err(eng_err), .eng_incr(eng_incr), .cur_ptr(cur_ptr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data while a read is on the bus
  always @(negedge clk) begin
    if (rst_n && bus_req && !bus_we) begin
      if (exp_q.size() == 0) begin
        chk("scoreboard underflow", 32'd1, 32'd0);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input int a, input int sz, input logic [31:0] d);
    @(negedge clk); #1;
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_size = 2'(sz); bus_wdata = d;
    @(negedge clk); #1;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, input int sz, input logic [31:0] e, input string tag);
    @(negedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = AW'(a); bus_size = 2'(sz);
    @(negedge clk); #1;
    bus_req = 1'b0;
  endtask

  task automatic done_pulse(input int ch, input logic e);
    @(negedge clk); #1;
    eng_done[ch] = 1'b1; eng_err[ch] = e;
    @(negedge clk); #1;
    eng_done[ch] = 1'b0; eng_err[ch] = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    chk("watchdog expired", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    rd(0, 0, 32'h0, "R12 cmd after reset");
    rd(2, 0, 32'h0, "R12 status after reset");
    rd(4, 2, 32'h0, "R12 base after reset");
    chk("R12 strobes after reset", {30'd0, eng_start | eng_abort}, 32'h0);
    chk("R12 cur_ptr after reset", cur_ptr[31:0], 32'h0);

    // R5 R6 word write aligns and reloads pointer
    wr(4, 2, 32'h1234_5677);
    rd(4, 2, 32'h1234_5674, "R5 word write aligned");
    chk("R6 pointer reloaded on word write", cur_ptr[31:0], 32'h1234_5674);
    rd(12, 2, 32'h0, "R8 ch1 base untouched");

    // R4 sub-word writes
    wr(5, 0, 32'h0000_00AB);
    rd(4, 2, 32'h1234_AB74, "R4 byte write offset 1");
    chk("R6 pointer reloaded on byte write", cur_ptr[31:0], 32'h1234_AB74);
    wr(4, 0, 32'h0000_00FF);
    rd(4, 2, 32'h1234_ABFC, "R5 byte write low bits cleared");
    wr(6, 1, 32'h0000_BEEF);
    rd(4, 2, 32'hBEEF_ABFC, "R4 halfword write offset 2");

    // R7 sub-word reads
    rd(5, 0, 32'h0000_00AB, "R7 byte read offset 1");
    rd(6, 1, 32'h0000_BEEF, "R7 half read offset 2");
    rd(5, 1, 32'h0000_EFAB, "R7 half read offset 1");
    rd(7, 0, 32'h0000_00BE, "R7 byte read offset 3");

    // R11 increment and priority
    @(negedge clk); #1; eng_incr[0] = 1'b1;
    @(negedge clk); #1; eng_incr[0] = 1'b0;
    chk("R11 increment by 8", cur_ptr[31:0], 32'hBEEF_AC04);
    rd(4, 2, 32'hBEEF_ABFC, "R11 base unchanged by increment");
    @(negedge clk); #1;
    eng_incr[0] = 1'b1; bus_req = 1'b1; bus_we = 1'b1; bus_addr = 4'd4; bus_size = 2'd2;
    bus_wdata = 32'h0000_0100;
    @(negedge clk); #1;
    eng_incr[0] = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
    chk("R11 write beats increment", cur_ptr[31:0], 32'h0000_0100);

    // R1 R3 start on idle
    wr(0, 0, 32'h0000_00FF);
    chk("R3 start strobe on idle", {30'd0, eng_start}, 32'h1);
    chk("R3 no abort on start", {30'd0, eng_abort}, 32'h0);
    chk("R1 direction bit out", {30'd0, eng_dir}, 32'h1);
    rd(0, 0, 32'h09, "R1 command masked");
    rd(2, 0, 32'h01, "R3 active set");
    wr(0, 0, 32'h0000_0001);
    chk("R3 no restart while active", {30'd0, eng_start}, 32'h0);
    rd(0, 0, 32'h01, "R3 command stored while active");

    // R9 active bit read-only
    wr(2, 0, 32'h0000_00FF);
    rd(2, 0, 32'h01, "R9 active survives status write");

    // R10 done without error
    done_pulse(0, 1'b0);
    rd(2, 0, 32'h04, "R10 done sets irq clears active");
    chk("R10 irq pin", {30'd0, irq}, 32'h1);
    wr(2, 0, 32'h0000_0004);
    rd(2, 0, 32'h00, "R9 irq cleared by write one");
    chk("R9 irq pin low", {30'd0, irq}, 32'h0);

    // R10 done with error
    wr(0, 0, 32'h0000_0001);
    chk("R3 second start", {30'd0, eng_start}, 32'h1);
    done_pulse(0, 1'b1);
    rd(2, 0, 32'h06, "R10 done with error");
    wr(2, 0, 32'h0000_0002);
    rd(2, 0, 32'h04, "R9 only error cleared");

    // R2 stop
    wr(0, 0, 32'h0000_0001);
    wr(0, 0, 32'h0000_0008);
    chk("R2 abort strobe on active stop", {30'd0, eng_abort}, 32'h1);
    rd(2, 0, 32'h04, "R2 active cleared by stop");
    rd(0, 0, 32'h08, "R2 stop value stored");
    wr(0, 0, 32'h0000_0000);
    chk("R2 no abort when idle", {30'd0, eng_abort}, 32'h0);

    // R8 channel independence and unit bit
    rd(10, 0, 32'h00, "R8 ch1 status untouched");
    wr(9, 0, 32'h0000_00FF);
    rd(9, 0, 32'h01, "R8 unit keeps one bit");
    chk("R8 unit pin", {30'd0, drv_unit}, 32'h2);
    wr(8, 0, 32'h0000_0001);
    chk("R8 ch1 start only", {30'd0, eng_start}, 32'h2);
    rd(2, 0, 32'h04, "R8 ch0 status after ch1 start");
    wr(12, 2, 32'hCAFE_F00D);
    chk("R8 ch1 pointer", cur_ptr[63:32], 32'hCAFE_F00C);
    chk("R8 ch0 pointer unchanged", cur_ptr[31:0], 32'h0000_0100);

    repeat (2) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule